// File: doc/BRIEF.md
# Lockable SMRAM Window Control Register

This block holds one byte-wide configuration register that governs a fixed 128 KB memory region kept for system-management code. It also contains the logic that decides whether each memory access may reach that region. Firmware finds out whether the feature exists with a handshake: it writes an all-ones query byte to the register and then reads the register back. A reply of 0x01 means the feature is present and the region is open to ordinary code.

Firmware then writes the lock byte. After that, the region is closed to any access made outside system-management mode, and the register accepts no further writes. Only a synchronous platform reset clears the lock, reopens the region and makes the register writable again.

A build-time parameter can remove the feature entirely. In that case the query reads back zero and the lock byte does nothing. The access port is purely combinational. It takes an address and a mode flag and returns allow or deny in the same cycle.

Top module: `smram_window_ctl`

## Requirements
- R1: After reset, a read at offset 0x9C returns 0x00 and every access, including non-SMM accesses into the window, is allowed.
- R2: With the feature present, writing 0xFF at offset 0x9C while unlocked makes later reads at 0x9C return 0x01.
- R3: Writing 0x02 at offset 0x9C while unlocked locks the register, from either the reset state or the open state, and later reads at 0x9C return 0x02.
- R4: Once locked, every write at offset 0x9C is ignored (0xFF, 0x00 and 0x01 included), and reads keep returning 0x02.
- R5: While locked, a non-SMM access to any address from 0x30000 through 0x4FFFF inclusive is denied (acc_allow = 0).
- R6: An access to an address below 0x30000 or above 0x4FFFF is always allowed, whatever the register state.
- R7: An access with acc_smm = 1 is always allowed, even into the window while locked.
- R8: While unlocked, a write at 0x9C of any value other than 0xFF or 0x02 leaves the register state and read value unchanged.
- R9: A read at any offset other than 0x9C returns 0x00, and a write at any other offset does not change the register.
- R10: When the feature parameter is off, a query reads back 0x00, the lock write has no effect, and window accesses stay allowed.
- R11: A reset after lock returns the register to 0x00, reopens the window to non-SMM accesses, and makes the register writable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low platform reset |
| cfg_off | input | OFF_W (8) | Configuration byte offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Read data for cfg_off, combinational |
| acc_addr | input | ADDR_W (32) | Address of the memory access being checked |
| acc_smm | input | 1 | The access comes from system-management mode |
| acc_allow | output | 1 | 1 = access permitted, 0 = denied |

## Verification
The assertions are checked on every clock cycle. They cover the following:
- The lock is sticky.
- Unrecognised values and writes to other offsets leave the state alone.
- A query moves the register to the open state.
- SMM accesses and accesses outside the window are never denied.
- A non-SMM access inside the locked window is always denied.
- With the feature off, the register never leaves its reset state.

Some behaviour can only be shown by the bench's scenarios. These are the exact byte values read back at each step of the handshake, the inclusive window edges at 0x30000 and 0x4FFFF together with their neighbours just outside, and the reopening of the window by a reset that comes after a lock.

// File: rtl/smwin_pkg.sv
// Package: shared state type and code bytes for the SMRAM window control block.
// Assumes byte-wide configuration data.
package smwin_pkg;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,   // no query or lock seen since reset
        WS_OPEN = 2'd1,   // feature acknowledged, window open
        WS_LOCK = 2'd2    // window closed, register read-only
    } win_state_e;

    localparam logic [7:0] CODE_QUERY = 8'hFF;
    localparam logic [7:0] CODE_LOCK  = 8'h02;
    localparam logic [7:0] RD_IDLE    = 8'h00;
    localparam logic [7:0] RD_OPEN    = 8'h01;
    localparam logic [7:0] RD_LOCK    = 8'h02;

    // Map a register state to the byte a read returns.
    function automatic logic [7:0] rd_code(input win_state_e s);
        case (s)
            WS_OPEN: rd_code = RD_OPEN;
            WS_LOCK: rd_code = RD_LOCK;
            default: rd_code = RD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/smwin_ctl_reg.sv
// Module: smwin_ctl_reg
// What it does: holds the state of the control register. A query byte opens
// the window (only when the feature is built in). A lock byte closes it and
// freezes the register until reset. All other writes are ignored.
// Assumes: writes take effect at the clock edge on which cfg_we is sampled high.
module smwin_ctl_reg
    import smwin_pkg::*;
#(
    parameter int                 OFF_W      = 8,
    parameter logic [OFF_W-1:0]   CTL_OFF    = 8'h9C,
    parameter bit                 FEATURE_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] cfg_off,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output win_state_e       state_q,
    output logic             locked
);

    logic       hit;
    win_state_e state_d;

    // Decode a write aimed at this register.
    always_comb begin
        hit = cfg_we && (cfg_off == CTL_OFF);
    end

    // Next-state logic: the query opens, the lock closes, anything else holds.
    always_comb begin
        state_d = state_q;
        if (FEATURE_EN && hit && (state_q != WS_LOCK)) begin
            if (cfg_wdata == CODE_QUERY) begin
                state_d = WS_OPEN;
            end else if (cfg_wdata == CODE_LOCK) begin
                state_d = WS_LOCK;
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Lock flag for the access gate.
    always_comb begin
        locked = (state_q == WS_LOCK);
    end

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_LOCK) |=> (state_q == WS_LOCK));

    // R8
    other_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_off == CTL_OFF && cfg_wdata != 8'hFF && cfg_wdata != 8'h02)
        |=> $stable(state_q));

    // R9
    no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_off == CTL_OFF) |=> $stable(state_q));

    generate
        if (FEATURE_EN) begin : g_feat
            // R2
            query_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_off == CTL_OFF && cfg_wdata == 8'hFF && state_q != WS_LOCK)
                |=> (state_q == WS_OPEN));
        end else begin : g_nofeat
            // R10
            never_leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == WS_IDLE));
        end
    endgenerate

endmodule

// File: rtl/smwin_win_dec.sv
// Module: smwin_win_dec
// What it does: flags addresses inside the fixed window [BASE, BASE+SIZE).
// Assumes: BASE+SIZE fits in ADDR_W+1 bits; the compare is unsigned.
module smwin_win_dec #(
    parameter int                ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 32'h0003_0000,
    parameter logic [ADDR_W-1:0] SIZE   = 32'h0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win
);

    localparam logic [ADDR_W:0] LO_X = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI_X = {1'b0, BASE} + {1'b0, SIZE};

    // Range compare, with the top bound exclusive.
    always_comb begin
        in_win = ({1'b0, addr} >= LO_X) && ({1'b0, addr} < HI_X);
    end

endmodule

// File: rtl/smwin_gate.sv
// Module: smwin_gate
// What it does: denies only non-SMM accesses that fall inside a locked window.
// Assumes: purely combinational; the inputs are already decoded.
module smwin_gate (
    input  logic in_win,
    input  logic smm,
    input  logic locked,
    output logic allow
);

    // Allow unless every deny condition holds.
    always_comb begin
        allow = !(in_win && !smm && locked);
    end

endmodule

// File: rtl/smram_window_ctl.sv
// Module: smram_window_ctl (top)
// What it does: one lockable control byte at CTL_OFF, plus the access gate
// for the fixed window reserved for system-management code.
// Assumes: a single configuration port; combinational read data and access result.
module smram_window_ctl
    import smwin_pkg::*;
#(
    parameter int                OFF_W      = 8,
    parameter logic [OFF_W-1:0]  CTL_OFF    = 8'h9C,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h0003_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE   = 32'h0002_0000,
    parameter bit                FEATURE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              acc_allow
);

    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

    win_state_e state_q;
    logic       locked;
    logic       in_win;

    smwin_ctl_reg #(
        .OFF_W      (OFF_W),
        .CTL_OFF    (CTL_OFF),
        .FEATURE_EN (FEATURE_EN)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_off   (cfg_off),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .state_q   (state_q),
        .locked    (locked)
    );

    smwin_win_dec #(
        .ADDR_W (ADDR_W),
        .BASE   (WIN_BASE),
        .SIZE   (WIN_SIZE)
    ) u_dec (
        .addr   (acc_addr),
        .in_win (in_win)
    );

    smwin_gate u_gate (
        .in_win (in_win),
        .smm    (acc_smm),
        .locked (locked),
        .allow  (acc_allow)
    );

    // Read mux: the register code at CTL_OFF, zero elsewhere.
    always_comb begin
        cfg_rdata = (cfg_off == CTL_OFF) ? rd_code(state_q) : 8'h00;
    end

    // R7
    smm_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_smm |-> acc_allow);

    // R6
    outside_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr < WIN_BASE || acc_addr > WIN_LAST) |-> acc_allow);

    // R5
    locked_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_LOCK && !acc_smm && acc_addr >= WIN_BASE && acc_addr <= WIN_LAST)
        |-> !acc_allow);

endmodule

// File: tb/sim_smram_window_ctl.sv
module sim_smram_window_ctl;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic [7:0]  off;
        logic [7:0]  wd;
        logic [31:0] addr;
        logic        smm;
        logic [7:0]  exp_rd;
        logic        exp_allow;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h9C, 8'h00, 32'h0003_0000, 1'b0, 8'h00, 1'b1, 4'd1},  // R1 reset state
        '{1'b1, 8'h9C, 8'h55, 32'h0004_FFFF, 1'b0, 8'h00, 1'b1, 4'd8},  // R8 ignored while idle
        '{1'b1, 8'h9C, 8'hFF, 32'h0003_0000, 1'b0, 8'h01, 1'b1, 4'd2},  // R2 query answered
        '{1'b1, 8'h9C, 8'h77, 32'h0003_0000, 1'b0, 8'h01, 1'b1, 4'd8},  // R8 ignored while open
        '{1'b1, 8'h9D, 8'h02, 32'h0004_0000, 1'b0, 8'h00, 1'b1, 4'd9},  // R9 other offset reads 0
        '{1'b0, 8'h9C, 8'h00, 32'h0004_0000, 1'b0, 8'h01, 1'b1, 4'd9},  // R9 that write had no effect
        '{1'b1, 8'h9C, 8'h02, 32'h0003_0000, 1'b0, 8'h02, 1'b0, 4'd3},  // R3 lock
        '{1'b0, 8'h9C, 8'h00, 32'h0004_FFFF, 1'b0, 8'h02, 1'b0, 4'd5},  // R5 top edge denied
        '{1'b0, 8'h9C, 8'h00, 32'h0002_FFFF, 1'b0, 8'h02, 1'b1, 4'd6},  // R6 just below
        '{1'b0, 8'h9C, 8'h00, 32'h0005_0000, 1'b0, 8'h02, 1'b1, 4'd6},  // R6 just above
        '{1'b0, 8'h9C, 8'h00, 32'h0003_0000, 1'b1, 8'h02, 1'b1, 4'd7},  // R7 SMM allowed
        '{1'b1, 8'h9C, 8'hFF, 32'h0003_FFFF, 1'b0, 8'h02, 1'b0, 4'd4},  // R4 query ignored
        '{1'b1, 8'h9C, 8'h00, 32'h0003_FFFF, 1'b0, 8'h02, 1'b0, 4'd4},  // R4 zero ignored
        '{1'b1, 8'h9C, 8'h01, 32'h0003_FFFF, 1'b0, 8'h02, 1'b0, 4'd4},  // R4 one ignored
        '{1'b0, 8'h9D, 8'h00, 32'h0003_FFFF, 1'b0, 8'h00, 1'b0, 4'd9}   // R9 other offset reads 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_off = 8'h9C;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic [7:0]  rd0, rd1;
    logic        al0, al1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smram_window_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_allow(al0)
    );

    smram_window_ctl #(.FEATURE_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_off(cfg_off), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_allow(al1)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Drive one cycle: set the inputs at the falling edge, then sample just after the rising edge.
    task automatic step(input logic we, input logic [7:0] off, input logic [7:0] wd,
                        input logic [31:0] addr, input logic smm);
        @(negedge clk);
        cfg_we = we; cfg_off = off; cfg_wdata = wd; acc_addr = addr; acc_smm = smm;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 value seen during reset
        chk("R1 rdata", rd0, 8'h00);
        chk("R1 allow", {7'b0, al0}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].off, VEC[i].wd, VEC[i].addr, VEC[i].smm);
            chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rd0, VEC[i].exp_rd);
            chk($sformatf("R%0d vec%0d allow", VEC[i].req, i), {7'b0, al0}, {7'b0, VEC[i].exp_allow});
        end

        // R11: a reset after lock reopens the window
        @(negedge clk);
        cfg_we = 1'b0; cfg_off = 8'h9C; acc_addr = 32'h0003_0000; acc_smm = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 rdata", rd0, 8'h00);
        chk("R11 allow", {7'b0, al0}, 8'h01);

        // R10 on u1 (feature off) plus R11 writable again on u0: query
        step(1'b1, 8'h9C, 8'hFF, 32'h0003_0000, 1'b0);
        chk("R11 writable again", rd0, 8'h01);
        chk("R10 query reads 0", rd1, 8'h00);

        // R3: lock from the open state on u0; R10: no effect on u1
        step(1'b1, 8'h9C, 8'h02, 32'h0003_0000, 1'b0);
        chk("R3 locked", rd0, 8'h02);
        chk("R5 denied", {7'b0, al0}, 8'h00);
        chk("R10 lock ignored", rd1, 8'h00);
        chk("R10 allow", {7'b0, al1}, 8'h01);

        // R3: lock straight from the reset state
        @(negedge clk);
        cfg_we = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 8'h9C, 8'h02, 32'h0004_FFFF, 1'b0);
        chk("R3 lock from idle", rd0, 8'h02);
        chk("R5 top edge", {7'b0, al0}, 8'h00);

        @(negedge clk);
        cfg_we = 1'b0;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

endmodule